// File: doc/BRIEF.md
# Two-Dimensional Vernier Fine Decoder

This block turns the contents of a two-dimensional Vernier sampling array into a time code with a 6.25 ps step. A fast ring oscillator (four differential cells of 50 ps, eight states per period) runs from the START trigger, and an upstream counter keeps track of its coarse progress. A second STOP trigger enables a slower ring whose cells are 56.25 ps. On each of the slower ring's rising and falling edges, a row of flip-flops captures the four taps of the fast ring. Each slower edge gains 6.25 ps on the fast ring, so the fast ring picks up one extra state at a column whose position encodes the residue of the interval inside one 50 ps coarse step.

The decoder reads the fast-ring state held in every column and finds the first column at which the fast ring has advanced one state more than the number of slow edges. From that column it forms a 3-bit fine value. It appends the fine value below the 5-bit coarse count, subtracts the slow ring's programmable start state (the sliding-scale offset, in fine steps), and registers an 8-bit result. Bad sample patterns raise an error flag beside the result: an illegal tap code, a column that is more than one state off, or a column that falls back after the crossing.

Top module: `vrn_fine_decoder`

## Requirements
- R1: A result appears with `out_valid` high for exactly one cycle after the third rising edge, counting the edge that captures `in_valid`. A new input is accepted on every cycle.
- R2: While `rst` is high at a rising edge, `out_valid`, `out_err` and `out_code` are cleared to zero.
- R3: Column k (k = 0..7) occupies `in_samples[4k+3:4k]`. Even columns are taken on slow-ring rising edges and odd columns on falling edges. Fast-ring state s is the 4-bit code with bits 0..s-1 set for s ≤ 4, and bits s-4..3 set for s > 4.
- R4: Column k ≥ 1 is a crossing when its state equals (state of column 0 + k + 1) mod 8. The fine value is 8 minus the index of the first crossing column.
- R5: When no column crosses, the fine value is 0.
- R6: `out_code` = ({`in_coarse`, fine} − `in_slide`) mod 256. A borrow out of the fine field decrements the coarse field, and the result wraps from 0 to 255.
- R7: `out_err` is set with the result when any column holds a tap pattern that is not one of the eight legal states of R3.
- R8: `out_err` is set when a column k ≥ 1 differs from (column 0 + k) mod 8 by anything other than 0 or 1, or when a column after the first crossing is not itself a crossing. Otherwise `out_err` is 0.
- R9: While `out_valid` is low, `out_code` keeps its last value.
- R10: For an interval T in [0, 1.6 ns), with the array, coarse count and slide offset produced by the two rings, `out_code` equals floor(T / 6.25 ps).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a conversion on the inputs |
| in_samples | input | 32 | Sampling array, eight columns of four fast-ring taps |
| in_coarse | input | 5 | Coarse count of fast-ring states |
| in_slide | input | 3 | Start state of the slow ring, in fine steps |
| out_valid | output | 1 | Result strobe |
| out_code | output | 8 | Merged time code, 6.25 ps per step |
| out_err | output | 1 | Sample pattern was illegal or non-monotonic |

## Verification
Every result, together with its error flag, is due three rising edges after the edge that captures it: one input register, one column-decode register and one merge register. The bench changes its inputs on falling edges and pushes the expected result for each cycle, or an idle marker, into a three-deep line. It compares the oldest entry with the outputs on the third falling edge after the push. Because of this, back-to-back conversions and idle gaps are checked cycle-exactly, and the hold of `out_code` during idle cycles is checked on the same timing.

// File: rtl/vrn_pkg.sv
package vrn_pkg;

  // Tap code of a differential ring with `taps` cells in state `st`
  // (0 <= st < 2*taps): ones fill from bit 0 upward, then empty from bit 0.
  function automatic logic [31:0] jcode(input int st, input int taps);
    logic [31:0] full;
    full = (32'd1 << taps) - 32'd1;
    if (st <= taps) return (32'd1 << st) - 32'd1;
    return (full << (st - taps)) & full;
  endfunction

endpackage

// File: rtl/vrn_phase_dec.sv
// Stage 2: decodes the tap pattern of every column into a ring state.
module vrn_phase_dec #(
  parameter int NCOL = 8,
  parameter int NTAP = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   in_valid,
  input  logic [NCOL*NTAP-1:0]                   in_samples,
  output logic                                   out_valid,
  output logic [NCOL*$clog2(2*NTAP)-1:0]         out_phase,
  output logic [NCOL-1:0]                        out_ok
);
  import vrn_pkg::*;

  localparam int NPH = 2 * NTAP;
  localparam int PW  = $clog2(NPH);

  logic v_q;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [NTAP-1:0] tap;
    logic [PW-1:0]   ph_c, ph_q;
    logic            ok_c, ok_q;

    assign tap = in_samples[c*NTAP +: NTAP];

    always_comb begin
      ph_c = '0;
      ok_c = 1'b0;
      for (int s = 0; s < NPH; s++) begin
        if (tap == NTAP'(jcode(s, NTAP))) begin
          ph_c = PW'(s);
          ok_c = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ph_q <= '0;
        ok_q <= 1'b0;
      end else if (in_valid) begin
        ph_q <= ph_c;
        ok_q <= ok_c;
      end
    end

    assign out_phase[c*PW +: PW] = ph_q;
    assign out_ok[c]             = ok_q;
  end

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else     v_q <= in_valid;
  end

  assign out_valid = v_q;

  AST_DEC_STAGE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1

endmodule

// File: rtl/vrn_cross_enc.sv
// Finds the crossing column and checks the pattern for consistency.
module vrn_cross_enc #(
  parameter int NCOL = 8,
  parameter int NTAP = 4
) (
  input  logic [NCOL*$clog2(2*NTAP)-1:0] in_phase,
  input  logic [NCOL-1:0]                in_ok,
  output logic [$clog2(NCOL)-1:0]        fine,
  output logic                           err
);
  localparam int PW = $clog2(2 * NTAP);
  localparam int FW = $clog2(NCOL);

  logic [PW-1:0]     ref_ph;
  logic [NCOL-1:1]   hit, same;
  logic              found, bubble;

  assign ref_ph = in_phase[PW-1:0];

  always_comb begin
    for (int k = 1; k < NCOL; k++) begin
      logic [PW-1:0] delta;
      delta   = PW'(in_phase[k*PW +: PW] - ref_ph - PW'(k));
      hit[k]  = (delta == PW'(1));
      same[k] = (delta == '0);
    end
  end

  always_comb begin
    fine   = '0;
    found  = 1'b0;
    bubble = 1'b0;
    for (int k = 1; k < NCOL; k++) begin
      if (!hit[k] && !same[k]) bubble = 1'b1;
      if (found && !hit[k])    bubble = 1'b1;
      if (hit[k] && !found) begin
        found = 1'b1;
        fine  = FW'(NCOL - k);
      end
    end
    err = bubble | ~(&in_ok);
  end

endmodule

// File: rtl/vrn_code_merge.sv
// Stage 3: joins coarse and fine, removes the sliding-scale start offset.
module vrn_code_merge #(
  parameter int CW = 5,
  parameter int FW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [CW-1:0]    in_coarse,
  input  logic [FW-1:0]    in_fine,
  input  logic [FW-1:0]    in_slide,
  input  logic             in_err,
  output logic             out_valid,
  output logic [CW+FW-1:0] out_code,
  output logic             out_err
);
  localparam int OW = CW + FW;

  logic [OW-1:0] raw, adj;
  logic          v_q, e_q;
  logic [OW-1:0] code_q;

  assign raw = {in_coarse, in_fine};
  assign adj = raw - OW'(in_slide);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q    <= 1'b0;
      e_q    <= 1'b0;
      code_q <= '0;
    end else begin
      v_q <= in_valid;
      e_q <= in_valid & in_err;
      if (in_valid) code_q <= adj;
    end
  end

  assign out_valid = v_q;
  assign out_err   = e_q;
  assign out_code  = code_q;

  AST_MERGE_STROBE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_MERGE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_ERR_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    out_err |-> out_valid); // R7
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_code)); // R9
  AST_NO_SLIDE_FINE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_slide == '0) |=> out_code[FW-1:0] == $past(in_fine)); // R6

endmodule

// File: rtl/vrn_fine_decoder.sv
module vrn_fine_decoder #(
  parameter int NCOL = 8,
  parameter int NTAP = 4,
  parameter int CW   = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [NCOL*NTAP-1:0]          in_samples,
  input  logic [CW-1:0]                 in_coarse,
  input  logic [$clog2(NCOL)-1:0]       in_slide,
  output logic                          out_valid,
  output logic [CW+$clog2(NCOL)-1:0]    out_code,
  output logic                          out_err
);
  localparam int FW = $clog2(NCOL);
  localparam int PW = $clog2(2 * NTAP);
  localparam int SW = NCOL * NTAP;

  // Stage 1: input capture
  logic          s1_valid;
  logic [SW-1:0] s1_samp;
  logic [CW-1:0] s1_coarse;
  logic [FW-1:0] s1_slide;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_samp   <= '0;
      s1_coarse <= '0;
      s1_slide  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_samp   <= in_samples;
        s1_coarse <= in_coarse;
        s1_slide  <= in_slide;
      end
    end
  end

  // Stage 2: per-column state decode, side data delayed alongside
  logic               dec_valid;
  logic [NCOL*PW-1:0] dec_phase;
  logic [NCOL-1:0]    dec_ok;
  logic [CW-1:0]      s2_coarse;
  logic [FW-1:0]      s2_slide;

  vrn_phase_dec #(.NCOL(NCOL), .NTAP(NTAP)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (s1_valid),
    .in_samples (s1_samp),
    .out_valid  (dec_valid),
    .out_phase  (dec_phase),
    .out_ok     (dec_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_coarse <= '0;
      s2_slide  <= '0;
    end else if (s1_valid) begin
      s2_coarse <= s1_coarse;
      s2_slide  <= s1_slide;
    end
  end

  // Crossing search (combinational between stage 2 and 3)
  logic [FW-1:0] x_fine;
  logic          x_err;

  vrn_cross_enc #(.NCOL(NCOL), .NTAP(NTAP)) u_cross (
    .in_phase (dec_phase),
    .in_ok    (dec_ok),
    .fine     (x_fine),
    .err      (x_err)
  );

  // Stage 3: merge and offset removal
  vrn_code_merge #(.CW(CW), .FW(FW)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (dec_valid),
    .in_coarse (s2_coarse),
    .in_fine   (x_fine),
    .in_slide  (s2_slide),
    .in_err    (x_err),
    .out_valid (out_valid),
    .out_code  (out_code),
    .out_err   (out_err)
  );

  AST_CAPTURE_STROBE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid); // R1
  AST_ERR_FLOW: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && x_err) |=> out_err); // R8
  AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !x_err) |=> !out_err); // R8

endmodule

// File: tb/sim_vrn_fine_decoder.sv
module sim_vrn_fine_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_samples = '0;
  logic [4:0]  in_coarse = '0;
  logic [2:0]  in_slide = '0;
  logic        out_valid;
  logic [7:0]  out_code;
  logic        out_err;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #5 clk = ~clk;

  vrn_fine_decoder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_samples(in_samples),
    .in_coarse(in_coarse), .in_slide(in_slide),
    .out_valid(out_valid), .out_code(out_code), .out_err(out_err)
  );

  // three-deep line of expectations, slot 2 is due now
  bit         ev[3];
  logic [7:0] ec[3];
  bit         ee[3];
  bit         ek[3];
  string      et[3];
  logic [7:0] last_code = 8'd0;

  function automatic logic [3:0] tapcode(int s); // R3 encoding
    if (s <= 4) return 4'((1 << s) - 1);
    return 4'((4'hF << (s - 4)) & 4'hF);
  endfunction

  // Times in 0.25 ps units: fast step 200, slow step 225, fine step 25.
  function automatic void rings(input int tp, output logic [31:0] smp,
                                output logic [4:0] crs);
    smp = '0;
    for (int k = 0; k < 8; k++) begin
      int n;
      n = (tp + 225 * k) / 200;
      smp[4*k +: 4] = tapcode(n % 8);
    end
    crs = 5'((tp / 200) % 32);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, logic [31:0] smp, logic [4:0] crs, logic [2:0] sl,
                      logic [7:0] code, bit err, bit chk_code, string tag);
    @(negedge clk);
    check(ev[2] ? et[2] : "R1", "out_valid", int'(out_valid), int'(ev[2]));
    if (ev[2]) begin
      check(et[2], "out_err", int'(out_err), int'(ee[2]));
      if (ek[2]) check(et[2], "out_code", int'(out_code), int'(ec[2]));
      last_code = out_code;
    end else begin
      check("R9", "held out_code", int'(out_code), int'(last_code));
    end
    for (int i = 2; i > 0; i--) begin
      ev[i] = ev[i-1]; ec[i] = ec[i-1]; ee[i] = ee[i-1];
      ek[i] = ek[i-1]; et[i] = et[i-1];
    end
    ev[0] = v; ec[0] = code; ee[0] = err; ek[0] = chk_code; et[0] = tag;
    in_valid = v; in_samples = smp; in_coarse = crs; in_slide = sl;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, '0, 1'b0, 1'b0, "R1");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] smp;
    logic [4:0]  crs;
    for (int i = 0; i < 3; i++) begin
      ev[i] = 1'b0; ec[i] = '0; ee[i] = 1'b0; ek[i] = 1'b0; et[i] = "R1";
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R2: reset state
    check("R2", "out_valid", int'(out_valid), 0);
    check("R2", "out_err",   int'(out_err),   0);
    check("R2", "out_code",  int'(out_code),  0);

    // R5: residue below one fine step, no crossing, code 72
    rings(200 * 9 + 10, smp, crs);
    step(1'b1, smp, crs, 3'd0, 8'd72, 1'b0, 1'b1, "R5");
    // R6: borrow out of the fine field, coarse 5 fine 2 slide 5 -> 37
    rings(200 * 5 + 50, smp, crs);
    step(1'b1, smp, crs, 3'd5, 8'd37, 1'b0, 1'b1, "R6");
    // R6: wrap below zero, coarse 0 fine 0 slide 3 -> 253
    rings(0, smp, crs);
    step(1'b1, smp, crs, 3'd3, 8'd253, 1'b0, 1'b1, "R6");
    idle(4);

    // R7: illegal tap pattern in column 5
    rings(1100, smp, crs);
    smp[23:20] = 4'b0101;
    step(1'b1, smp, crs, 3'd0, 8'd0, 1'b1, 1'b0, "R7");
    // R8: residue 100 crosses at column 4; column 6 falls back
    rings(1100, smp, crs);
    smp[27:24] = tapcode((((1100 / 200) % 8) + 6) % 8);
    step(1'b1, smp, crs, 3'd0, 8'd0, 1'b1, 1'b0, "R8");
    // R8: column 2 two states ahead
    rings(1100, smp, crs);
    smp[11:8] = tapcode((((1100 / 200) % 8) + 4) % 8);
    step(1'b1, smp, crs, 3'd0, 8'd0, 1'b1, 1'b0, "R8");
    // R4: same interval untouched, fine 4 -> 8*5+4 = 44
    rings(1100, smp, crs);
    step(1'b1, smp, crs, 3'd0, 8'd44, 1'b0, 1'b1, "R4");
    idle(5);

    // R10 sweep over all slide offsets, covering R3 R4 R6; back-to-back
    // with idle gaps that also exercise R9
    begin
      int cnt;
      cnt = 0;
      for (int sl = 0; sl < 8; sl++) begin
        for (int t = 0; t < 6400; t += 5) begin
          rings(t + 25 * sl, smp, crs);
          step(1'b1, smp, crs, 3'(sl), 8'(t / 25), 1'b0, 1'b1, "R10");
          cnt++;
          if (cnt % 17 == 0) idle(2);
        end
      end
    end
    idle(4);
    finish_run();
  end

endmodule